// File: doc/BRIEF.md
# Framed Bit-Serial Adder

This block adds two unsigned words that arrive one bit pair per clock, least significant bit first, and returns the sum in the same order, one bit per clock. The arithmetic is a single full adder with a carry flip-flop. A small controller frames each word. A `start` pulse while idle opens a word and forces the carry-in of the first bit to zero. The controller then accepts exactly `WORD_W` bit pairs and returns to idle.

Each sum bit is registered. It appears one clock after its operand pair is sampled and is qualified by `sum_valid`. On the clock that carries the last sum bit, `word_done` pulses and `carry_out` shows the carry out of the top bit. A new word may start on the clock right after the last bit pair, so words can run back to back with no gap.

Top module: `bit_serial_adder`

## Requirements
- R1: After reset, `sum_valid`, `sum_bit`, `word_done` and `carry_out` are all 0.
- R2: When `start` is 1 while idle, the bit pair on that same clock is bit 0 of a new word, and its carry-in is 0 whatever carry the previous word left behind.
- R3: A word consists of exactly `WORD_W` bit pairs, sampled on the start clock and the `WORD_W-1` clocks that follow. `sum_valid` is 1 on exactly `WORD_W` consecutive clocks, each one clock after the matching bit pair.
- R4: Sum bit i equals bit i of A+B, least significant first. `sum_bit` is 0 whenever `sum_valid` is 0.
- R5: `word_done` is a one-clock pulse on the clock of the last sum bit of a word. On that clock `carry_out` equals bit `WORD_W` of A+B, and it holds that value until the next `word_done`.
- R6: A `start` asserted while a word is in progress has no effect on that word's sum bits, length or carry.
- R7: Once a word ends, operand bits are ignored until the next `start`: `sum_valid` stays 0 and `carry_out` does not change.
- R8: A `start` on the clock directly after a word's last bit pair opens the next word with no idle gap.
- R9: With a 4-bit word, adding 0110 and 1100 gives the sum bits 0,1,0,0 (LSB first) with `carry_out` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a word when idle; its clock carries bit 0 |
| a_bit | input | 1 | Operand A bit for the current bit time |
| b_bit | input | 1 | Operand B bit for the current bit time |
| sum_bit | output | 1 | Registered sum bit, 0 when not valid |
| sum_valid | output | 1 | `sum_bit` holds a sum bit of the current word |
| carry_out | output | 1 | Carry out of the top bit of the last finished word |
| word_done | output | 1 | One-clock pulse with the last sum bit of a word |

## Verification
Some properties hold on every clock, and assertions check those. The bit counter stays in range. A word that has not reached its last bit keeps running. A sum is valid exactly one clock after a bit was accepted. The done pulse follows the last bit and lines up with a valid sum. The sum bit is zero whenever it is not valid. Arithmetic correctness cannot be checked cycle by cycle, and neither can the clearing of the carry between words. Only the bench can show these, by comparing whole words against the integer sum. It does this for random operands, for the fixed 0110 + 1100 case, and for a 1111 + 1111 word followed back to back by 0000 + 0000. The same scenarios also inject spurious starts mid-word and noisy bits while idle.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_RUN  = 1'b1
  } ctl_state_e;

  // One-bit full adder: sum output
  function automatic logic fa_sum(input logic x, input logic y, input logic cin);
    return x ^ y ^ cin;
  endfunction

  // One-bit full adder: carry output (majority)
  function automatic logic fa_carry(input logic x, input logic y, input logic cin);
    return (x & y) | (x & cin) | (y & cin);
  endfunction

endpackage

// File: rtl/bsa_ctrl.sv
module bsa_ctrl #(
  parameter int WORD_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic clear_carry,
  output logic last_bit,
  output logic running
);
  import bsa_pkg::*;

  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  ctl_state_e        state_q, state_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic              open_word;

  assign open_word   = (state_q == CTL_IDLE) && start;
  assign running     = (state_q == CTL_RUN);
  assign accept      = open_word || running;
  assign clear_carry = open_word;
  // index of the bit taken this clock: 0 on the opening clock
  assign last_bit    = open_word ? (WORD_W == 1) : (running && idx_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (open_word) begin
      idx_d   = CNT_W'(1);
      state_d = (WORD_W == 1) ? CTL_IDLE : CTL_RUN;
    end else if (running) begin
      if (idx_q == LAST_IDX) begin
        state_d = CTL_IDLE;
        idx_d   = '0;
      end else begin
        idx_d = idx_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX); // R3
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && idx_q != LAST_IDX) |=> running); // R6
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (running && idx_q == LAST_IDX) |=> !running || WORD_W == 1); // R7

endmodule

// File: rtl/bsa_datapath.sv
module bsa_datapath (
  input  logic clk,
  input  logic rst_n,
  input  logic a_bit,
  input  logic b_bit,
  input  logic accept,
  input  logic clear_carry,
  input  logic last_bit,
  output logic sum_bit,
  output logic sum_valid,
  output logic word_done,
  output logic carry_out
);
  import bsa_pkg::*;

  logic carry_q;
  logic cin;
  logic fa_s, fa_c;

  assign cin  = clear_carry ? 1'b0 : carry_q;
  assign fa_s = fa_sum(a_bit, b_bit, cin);
  assign fa_c = fa_carry(a_bit, b_bit, cin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q   <= 1'b0;
      sum_bit   <= 1'b0;
      sum_valid <= 1'b0;
      word_done <= 1'b0;
      carry_out <= 1'b0;
    end else begin
      sum_valid <= accept;
      word_done <= accept && last_bit;
      sum_bit   <= accept ? fa_s : 1'b0;
      if (accept)            carry_q   <= fa_c;
      if (accept && last_bit) carry_out <= fa_c;
    end
  end

  AST_VALID_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> sum_valid); // R3
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !sum_valid); // R7
  AST_SUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_valid |-> !sum_bit); // R4
  AST_COUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && last_bit) |=> $stable(carry_out)); // R5

endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int WORD_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic a_bit,
  input  logic b_bit,
  output logic sum_bit,
  output logic sum_valid,
  output logic carry_out,
  output logic word_done
);

  logic accept_w, clear_w, last_w, running_w;

  bsa_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .accept     (accept_w),
    .clear_carry(clear_w),
    .last_bit   (last_w),
    .running    (running_w)
  );

  bsa_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_bit      (a_bit),
    .b_bit      (b_bit),
    .accept     (accept_w),
    .clear_carry(clear_w),
    .last_bit   (last_w),
    .sum_bit    (sum_bit),
    .sum_valid  (sum_valid),
    .word_done  (word_done),
    .carry_out  (carry_out)
  );

  AST_DONE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> sum_valid); // R5
  AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> word_done); // R5
  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_w |-> !running_w); // R6

endmodule

// File: tb/tb_bit_serial_adder.sv
module tb_bit_serial_adder;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, a_bit = 1'b0, b_bit = 1'b0;
  logic sum_bit, sum_valid, carry_out, word_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic e_valid = 1'b0, e_sum = 1'b0, e_done = 1'b0, e_cout = 1'b0;

  always #5 clk = ~clk;

  bit_serial_adder #(.WORD_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_bit(a_bit), .b_bit(b_bit),
    .sum_bit(sum_bit), .sum_valid(sum_valid), .carry_out(carry_out), .word_done(word_done)
  );

  function automatic logic ref_bit(input logic [W-1:0] x, input logic [W-1:0] y, input int i);
    logic [W:0] t;
    t = {1'b0, x} + {1'b0, y};
    return t[i];
  endfunction

  task automatic cmp(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // check the outputs of the previous clock, then drive the next inputs
  task automatic step(input string tag, input logic st, input logic a, input logic b,
                      input logic nv, input logic ns, input logic nd, input logic nc);
    @(negedge clk);
    cmp(tag, "sum_valid", sum_valid, e_valid);
    cmp(tag, "sum_bit",   sum_bit,   e_sum);
    cmp(tag, "word_done", word_done, e_done);
    cmp(tag, "carry_out", carry_out, e_cout);
    start = st; a_bit = a; b_bit = b;
    e_valid = nv; e_sum = ns; e_done = nd; e_cout = nc;
  endtask

  task automatic word(input string tag, input logic [W-1:0] x, input logic [W-1:0] y,
                      input bit noisy_start);
    for (int i = 0; i < W; i++) begin
      logic st;
      st = (i == 0) ? 1'b1 : (noisy_start ? 1'($urandom_range(0, 1)) : 1'b0);
      step(tag, st, x[i], y[i], 1'b1, ref_bit(x, y, i), (i == W-1),
           (i == W-1) ? ref_bit(x, y, W) : e_cout);
    end
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++)
      step(tag, 1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'b0, 1'b0, 1'b0, e_cout);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2005));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset state
    idle("R1", 2);
    // R9: directed example 0110 + 1100
    word("R9", 4'b0110, 4'b1100, 1'b0);
    idle("R7", 3);
    // R2 R8: carry-generating word then back to back zero word
    word("R2", 4'b1111, 4'b1111, 1'b0);
    word("R8", 4'b0000, 4'b0000, 1'b0);
    idle("R7", 2);
    word("R5", 4'b1000, 4'b1000, 1'b0);
    word("R8", 4'b0001, 4'b1111, 1'b0);
    idle("R7", 4);
    // R6: spurious starts inside words
    for (int n = 0; n < 40; n++) begin
      word("R6", 4'($urandom), 4'($urandom), 1'b1);
      idle("R7", $urandom_range(0, 2));
    end
    // R3 R4: random operands, random gaps
    for (int n = 0; n < 200; n++) begin
      word("R4", 4'($urandom), 4'($urandom), 1'b0);
      if ($urandom_range(0, 1) == 1) idle("R3", $urandom_range(1, 3));
    end
    idle("R7", 3);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule